// File: doc/BRIEF.md
# Burst ROM Read Cycle Controller

This block runs the external bus cycles for one memory region that holds burst-capable ROM. A host hands it one request at a time over a valid/acknowledge port. The request carries an address, a write flag and a flag that marks the read as fit for bursting. The controller then drives chip select, the read or write strobe and the address, and pulses a data-valid signal back to the host at the end of each beat.

A read that is fit for bursting starts with a single full access. The full access can be stretched by a programmed wait count and by an external wait input. It is followed by a run of short burst beats in which only the low address bits step forward, wrapping inside the aligned block. Chip select stays low across the whole run. Any other access, such as a write or a read without the burst flag, is one plain access whose timing follows the per-region settings for chip-select extension and delayed strobe release. For burst reads those two settings are overridden.

Top module: `brc_burst_rom_ctl`

## Requirements
- R1: While reset is asserted and after it is released, with no request pending, bus_cs_n, bus_rd_n and bus_wr_n are high and host_rvalid and host_done are low.
- R2: A burst read (req_burst_ok=1, req_write=0) always gets exactly one extension cycle, with chip select low and both strobes high, before its full access, whatever cfg_cs_ext says. No extension cycle follows its last beat.
- R3: The full access lasts 2 + cfg_wait cycles. ext_wait is sampled from the last programmed cycle on, and each cycle in which it is sampled high adds one more cycle.
- R4: After the full access, a burst read runs 3 further beats when cfg_len8=0 and 7 when cfg_len8=1. Each beat lasts 1 cycle when cfg_beat2=0 and 2 cycles when cfg_beat2=1, and ext_wait has no effect on them.
- R5: In beat n (the full access being beat 0), bus_addr keeps the upper bits of the request address. Its low 2 bits (cfg_len8=0) or low 3 bits (cfg_len8=1) equal the request's low bits plus n, modulo the burst length.
- R6: Chip select stays low without a break from the first cycle of an access to its last. It is then high for at least two cycles before the next access begins.
- R7: On a burst read, bus_rd_n is low throughout the full access and every burst beat. It goes high in the first cycle after the last beat, and cfg_rd_late is ignored.
- R8: An access that is not a burst read is a single full access. It is preceded by one extension cycle and followed by one extension cycle, chip select low and strobes high, exactly when cfg_cs_ext=1.
- R9: For a non-burst read with cfg_rd_late=1, bus_rd_n stays low for one extra cycle after the full access. That cycle is the trailing extension cycle if there is one, and otherwise the first idle cycle.
- R10: A write drives bus_wr_n low during its full access only, keeps bus_rd_n high and never raises host_rvalid.
- R11: For reads, host_rvalid is high for one cycle in the last cycle of each beat. host_done is high for exactly one cycle, the cycle right after the last cycle of the access (including any trailing extension).
- R12: req_ack is high only in a cycle where the controller is idle and req_valid is high. A request held during an access is not acknowledged until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Request is a write |
| req_burst_ok | input | 1 | Read may run as a burst (initiator qualifies) |
| req_addr | input | AW | Request start address |
| req_ack | output | 1 | Request accepted this cycle |
| cfg_wait | input | WAIT_W | Programmed wait cycles for the full access |
| cfg_beat2 | input | 1 | Burst beats last two cycles instead of one |
| cfg_len8 | input | 1 | Burst length 8 beats instead of 4 |
| cfg_cs_ext | input | 1 | Region setting: extension cycles around basic accesses |
| cfg_rd_late | input | 1 | Region setting: delayed read strobe release for basic reads |
| ext_wait | input | 1 | External wait request, active high |
| bus_addr | output | AW | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| host_rvalid | output | 1 | Read data valid pulse at the end of each beat |
| host_done | output | 1 | Access complete pulse |

## Verification
Burst reads are run with both burst lengths and both beat widths, and from start addresses whose low bits force the address to wrap. These runs separate the low-bit stepping from a plain increment and show the beat timing. Burst reads are also run with the region settings switched on and with the wait input held through the beats. Such runs show that the overrides take effect and that waits only stretch the full access. Plain reads and writes are run with each combination of extension and delayed release, so any leaked burst behaviour or misplaced strobe shows up. A request held high across a burst tells a correct acknowledge apart from one that fires mid-access.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PRE   = 3'd1,
    S_FULL  = 3'd2,
    S_BURST = 3'd3,
    S_POST  = 3'd4,
    S_GAP   = 3'd5
  } brc_state_e;

  typedef struct packed {
    logic is_wr;
    logic qual;
  } brc_kind_t;

endpackage

// File: rtl/brc_full_timer.sv
module brc_full_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              ext_wait,
  output logic              full_last
);

  localparam int CNT_W = WAIT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] prog_end;

  assign prog_end = {1'b0, wait_cfg} + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign full_last = en && (cnt_q >= prog_end) && !ext_wait;

endmodule

// File: rtl/brc_beat_ctr.sv
module brc_beat_ctr #(
  parameter int BEAT_LOG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                burst_en,
  input  logic                advance,
  input  logic                two_cyc,
  input  logic                len_long,
  output logic [BEAT_LOG-1:0] beat_idx,
  output logic                last_cyc,
  output logic                final_beat
);

  localparam logic [BEAT_LOG-1:0] LAST_LONG  = '1;
  localparam logic [BEAT_LOG-1:0] LAST_SHORT = LAST_LONG >> 1;

  logic [BEAT_LOG-1:0] beat_q;
  logic [BEAT_LOG-1:0] beat_d;
  logic                sub_q;
  logic                sub_d;

  assign last_cyc   = !two_cyc || sub_q;
  assign final_beat = beat_q == (len_long ? LAST_LONG : LAST_SHORT);
  assign beat_idx   = beat_q;

  always_comb begin
    beat_d = beat_q;
    if (clear) begin
      beat_d = '0;
    end else if (advance) begin
      beat_d = beat_q + BEAT_LOG'(1);
    end
    sub_d = burst_en && !last_cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      sub_q  <= 1'b0;
    end else begin
      beat_q <= beat_d;
      sub_q  <= sub_d;
    end
  end

  // R5: a short burst never indexes past its fourth beat
  p_beat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_en && !len_long) |-> (beat_q <= LAST_SHORT));

endmodule

// File: rtl/brc_addr_gen.sv
module brc_addr_gen #(
  parameter int AW       = 16,
  parameter int BEAT_LOG = 3
) (
  input  logic [AW-1:0]       base,
  input  logic [BEAT_LOG-1:0] beat,
  input  logic                len_long,
  output logic [AW-1:0]       addr
);

  localparam logic [AW-1:0] MASK_LONG  = AW'((1 << BEAT_LOG) - 1);
  localparam logic [AW-1:0] MASK_SHORT = AW'((1 << (BEAT_LOG - 1)) - 1);

  logic [AW-1:0] mask;
  logic [AW-1:0] stepped;

  assign mask    = len_long ? MASK_LONG : MASK_SHORT;
  assign stepped = base + AW'(beat);
  assign addr    = (base & ~mask) | (stepped & mask);

endmodule

// File: rtl/brc_burst_rom_ctl.sv
module brc_burst_rom_ctl
  import brc_pkg::*;
#(
  parameter int AW       = 16,
  parameter int WAIT_W   = 3,
  parameter int BEAT_LOG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst_ok,
  input  logic [AW-1:0]     req_addr,
  output logic              req_ack,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_beat2,
  input  logic              cfg_len8,
  input  logic              cfg_cs_ext,
  input  logic              cfg_rd_late,
  input  logic              ext_wait,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              host_rvalid,
  output logic              host_done
);

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_q = rs_q[1];

  brc_state_e          st_q, st_d;
  brc_kind_t           kind_q, kind_d;
  logic [AW-1:0]       base_q, base_d;
  logic                late_q, late_d;

  logic                full_last;
  logic                burst_last_cyc;
  logic                burst_final;
  logic [BEAT_LOG-1:0] beat_idx;
  logic                in_full;
  logic                in_burst;
  logic                beat_adv;
  logic                new_qual;

  assign in_full  = st_q == S_FULL;
  assign in_burst = st_q == S_BURST;
  assign new_qual = req_burst_ok && !req_write;
  assign beat_adv = (in_full && full_last && kind_q.qual) ||
                    (in_burst && burst_last_cyc);

  brc_full_timer #(.WAIT_W(WAIT_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .en        (in_full),
    .wait_cfg  (cfg_wait),
    .ext_wait  (ext_wait),
    .full_last (full_last)
  );

  brc_beat_ctr #(.BEAT_LOG(BEAT_LOG)) beat_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .clear      (!(in_full || in_burst)),
    .burst_en   (in_burst),
    .advance    (beat_adv),
    .two_cyc    (cfg_beat2),
    .len_long   (cfg_len8),
    .beat_idx   (beat_idx),
    .last_cyc   (burst_last_cyc),
    .final_beat (burst_final)
  );

  brc_addr_gen #(.AW(AW), .BEAT_LOG(BEAT_LOG)) addr_i (
    .base     (base_q),
    .beat     (beat_idx),
    .len_long (cfg_len8),
    .addr     (bus_addr)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    base_d = base_q;
    late_d = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          kind_d.is_wr = req_write;
          kind_d.qual  = new_qual;
          base_d       = req_addr;
          st_d         = (new_qual || cfg_cs_ext) ? S_PRE : S_FULL;
        end
      end
      S_PRE: st_d = S_FULL;
      S_FULL: begin
        if (full_last) begin
          late_d = !kind_q.is_wr && !kind_q.qual && cfg_rd_late;
          if (kind_q.qual) begin
            st_d = S_BURST;
          end else if (cfg_cs_ext) begin
            st_d = S_POST;
          end else begin
            st_d = S_GAP;
          end
        end
      end
      S_BURST: begin
        if (burst_last_cyc && burst_final) begin
          st_d = S_GAP;
        end
      end
      S_POST: st_d = S_GAP;
      S_GAP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= S_IDLE;
      kind_q <= '0;
      base_q <= '0;
      late_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      base_q <= base_d;
      late_q <= late_d;
    end
  end

  // outputs
  assign req_ack     = (st_q == S_IDLE) && req_valid;
  assign bus_cs_n    = (st_q == S_IDLE) || (st_q == S_GAP);
  assign bus_rd_n    = !((!kind_q.is_wr && (in_full || in_burst)) || late_q);
  assign bus_wr_n    = !(kind_q.is_wr && in_full);
  assign host_rvalid = !kind_q.is_wr &&
                       ((in_full && full_last) || (in_burst && burst_last_cyc));
  assign host_done   = st_q == S_GAP;

  // R2: once chip select drops, a strobe is active in the next cycle
  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(bus_cs_n) |=> (!bus_rd_n || !bus_wr_n));

  // R2: a burst read releases its strobe together with chip select
  p_no_post_ext_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (kind_q.qual && $rose(bus_rd_n)) |-> bus_cs_n);

  // R3: no beat may end while the wait input holds the full access
  p_wait_stretch_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (in_full && ext_wait) |-> !host_rvalid);

  // R4: single-cycle beats deliver data on every burst cycle
  p_burst_nowait_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (in_burst && !cfg_beat2) |-> host_rvalid);

  // R6: chip select stays high for more than one cycle between accesses
  p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(bus_cs_n) |=> bus_cs_n);

  // R11: data valid only while the read strobe and chip select are active
  p_rvalid_strobe_r11: assert property (@(posedge clk) disable iff (!rst_q)
    host_rvalid |-> (!bus_rd_n && !bus_cs_n));

  // R11: completion follows a cycle with chip select active
  p_done_after_r11: assert property (@(posedge clk) disable iff (!rst_q)
    host_done |-> $past(!bus_cs_n));

  // R12: acceptance only while the bus is released
  p_ack_idle_r12: assert property (@(posedge clk) disable iff (!rst_q)
    req_ack |-> bus_cs_n);

endmodule

// File: tb/brc_burst_rom_ctl_tb_top.sv
`timescale 1ns/1ps
module brc_burst_rom_ctl_tb_top;

  localparam int AW = 16;
  localparam int WW = 3;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write, req_burst_ok;
  logic [AW-1:0] req_addr;
  logic          req_ack;
  logic [WW-1:0] cfg_wait;
  logic          cfg_beat2, cfg_len8, cfg_cs_ext, cfg_rd_late;
  logic          ext_wait;
  logic [AW-1:0] bus_addr;
  logic          bus_cs_n, bus_rd_n, bus_wr_n, host_rvalid, host_done;

  int n_chk;
  int n_bad;
  bit finished;

  brc_burst_rom_ctl #(.AW(AW), .WAIT_W(WW), .BEAT_LOG(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_burst_ok(req_burst_ok),
    .req_addr(req_addr), .req_ack(req_ack),
    .cfg_wait(cfg_wait), .cfg_beat2(cfg_beat2), .cfg_len8(cfg_len8),
    .cfg_cs_ext(cfg_cs_ext), .cfg_rd_late(cfg_rd_late), .ext_wait(ext_wait),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .host_rvalid(host_rvalid), .host_done(host_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // control vector: {ack, cs_n, rd_n, wr_n, rvalid, done}
  function automatic logic [5:0] ctl_vec();
    return {req_ack, bus_cs_n, bus_rd_n, bus_wr_n, host_rvalid, host_done};
  endfunction

  task automatic run_access(input string tag, input bit wr, input bit bok,
                            input logic [AW-1:0] a, input int w, input int wn,
                            input bit b2, input bit l8, input bit cx, input bit rl,
                            input bit hold_burst, input bit keep_req);
    bit qual;
    int p, f, nb, bc, bcy, q, g, endc, lb, mask;
    qual = bok && !wr;
    p    = (qual || cx) ? 1 : 0;
    endc = (1 + w > wn) ? 1 + w : wn;
    f    = endc + 1;
    nb   = qual ? (l8 ? 8 : 4) : 1;
    bc   = b2 ? 2 : 1;
    bcy  = (nb - 1) * bc;
    q    = qual ? 0 : (cx ? 1 : 0);
    g    = 1 + p + f + bcy + q;
    lb   = l8 ? 3 : 2;
    mask = (1 << lb) - 1;
    for (int k = 0; k <= g; k++) begin
      int  c, beat;
      bit  infull, inburst, cs, rdl, wrl, rv, dn, ak;
      logic [AW-1:0] ea;
      @(posedge clk);
      #1;
      if (k == 0) begin
        req_write    = wr;
        req_burst_ok = bok;
        req_addr     = a;
        cfg_wait     = WW'(w);
        cfg_beat2    = b2;
        cfg_len8     = l8;
        cfg_cs_ext   = cx;
        cfg_rd_late  = rl;
      end
      c       = k - 1 - p;
      infull  = (c >= 0) && (c < f);
      inburst = (c >= f) && (c < f + bcy);
      req_valid = (k == 0) || keep_req;
      ext_wait  = ((c >= 0) && (c < wn)) || (hold_burst && inburst);
      @(negedge clk);
      cs  = (k >= 1) && (k < g);
      rdl = (!wr && (infull || inburst)) || (!wr && !qual && rl && c == f);
      wrl = wr && infull;
      rv  = !wr && ((c == f - 1) || (inburst && ((c - f) % bc == bc - 1)));
      dn  = (k == g);
      ak  = (k == 0);
      check(tag, 32'(ctl_vec()), 32'({ak, !cs, !rdl, !wrl, rv, dn}));
      if (cs) begin
        beat = inburst ? 1 + (c - f) / bc : 0;
        ea   = (a & ~AW'(mask)) | ((a + AW'(beat)) & AW'(mask));
        check("R5 address", 32'(bus_addr), 32'(ea));
      end
    end
    req_valid = keep_req;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_burst_ok = 0; req_addr = '0;
    cfg_wait = '0; cfg_beat2 = 0; cfg_len8 = 0; cfg_cs_ext = 0; cfg_rd_late = 0;
    ext_wait = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'({bus_cs_n, bus_rd_n, bus_wr_n, host_rvalid, host_done}), 32'b11100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 32'({bus_cs_n, bus_rd_n, bus_wr_n, host_rvalid, host_done}), 32'b11100);
  endtask

  task automatic t_burst4_basic();
    // R2 R4 R7 R11: overrides ignore cs_ext=0 and rd_late=1, address wraps
    run_access("R2 R7 R11 burst4", 0, 1, 16'h1232, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_burst8_slow();
    // R4 R5: eight two-cycle beats with wrap in 3 low bits, cs_ext=1 ignored
    run_access("R4 R5 burst8", 0, 1, 16'h00A5, 3, 0, 1, 1, 1, 0, 0, 0);
  endtask

  task automatic t_burst_waits();
    // R3 R4: pin stretches full access, ignored across beats
    run_access("R3 R4 burst waits", 0, 1, 16'h4003, 1, 5, 0, 0, 1, 1, 1, 0);
    run_access("R3 R4 slow beats wait", 0, 1, 16'h7FFE, 0, 0, 1, 0, 0, 0, 1, 0);
  endtask

  task automatic t_basic_reads();
    // R8 R9: basic reads with each extension and late release combination
    run_access("R8 R9 read ext late", 0, 0, 16'h2222, 2, 0, 0, 1, 1, 1, 0, 0);
    run_access("R8 R3 read plain", 0, 0, 16'h3333, 0, 2, 0, 0, 0, 0, 0, 0);
    run_access("R9 read late no ext", 0, 0, 16'h0101, 1, 0, 1, 0, 0, 1, 0, 0);
  endtask

  task automatic t_writes();
    // R10 R8: writes never burst, even with burst_ok set
    run_access("R10 R8 write ext", 1, 1, 16'h5555, 0, 0, 0, 1, 1, 1, 0, 0);
    run_access("R10 R3 write long", 1, 0, 16'h6666, 7, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_held_req();
    // R12 R6: held request acknowledged only when idle again
    run_access("R12 R6 held req", 0, 1, 16'h0007, 0, 0, 0, 0, 0, 0, 0, 1);
    run_access("R12 R6 held req next", 0, 1, 16'h0007, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 0;
    t_reset();
    t_burst4_basic();
    t_burst8_slow();
    t_burst_waits();
    t_basic_reads();
    t_writes();
    t_held_req();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule